// File: doc/BRIEF.md
# Streaming Pipelined Accumulator with Operand Pairing

This block adds up one stream of integer operands of any length and gives back a single total. Its adder has a pipeline latency of `LAT` cycles. A combinational adder followed by a `LAT`-stage delay line models a deep arithmetic core such as a floating-point adder. The block does not wait `LAT` cycles after each element. Instead it pairs operands as they come: a fresh input, the contents of one holding register, and partial sums coming back out of the adder. The adder starts an addition only when it has two operands, so no operand is lost or counted twice.

A producer presents `data_in` with `data_valid` and marks the final element with `data_last`. Once that marker has been taken, the block keeps combining partial sums until only one value is left, held in the register, with the adder pipeline empty. It then raises `result_ready` for one cycle with the total on `result`. The next stream may begin in the cycle right after that pulse.

Top module: `dbacc_top`

## Requirements
- R1: During reset and in the first cycle after it, `result_ready` is low.
- R2: A valid input that arrives when the adder delivers no sum and the holding register is empty is stored in the register. A one-element stream therefore produces that element on `result`, with `result_ready` high in the cycle after the element, counting the element's cycle as cycle 0.
- R3: A valid input that arrives while the register holds data and no sum is leaving the adder is sent to the adder together with the register value, and the register becomes empty.
- R4: A sum leaving the adder while the register holds data and no input arrives is sent back into the adder together with the register value, and the register becomes empty. A sum that leaves with neither an input nor register data present is stored in the register.
- R5: When a valid input and a leaving sum coincide, the two are added together, and the register keeps its value and its occupancy unchanged.
- R6: Each addition enters the `LAT`-stage pipeline, and its sum leaves exactly `LAT` cycles after its operands entered. `result_ready` is raised only when all of these hold: the last element has been taken, no addition is in flight, and the register holds the remaining value.
- R7: `result_ready` is high for exactly one cycle per stream. In that cycle `result` equals the sum of the stream modulo 2^`DW`.
- R8: With `LAT`=2, four elements on cycles 0 to 3 give a final sum leaving the adder in cycle 7 and `result_ready` in cycle 8. Two elements on cycles 0 and 1 give `result_ready` in cycle 4.
- R9: Any `data_valid` from the cycle after the last element is taken up to and including the `result_ready` cycle is ignored and does not change the result.
- R10: A new stream may start in the cycle directly after `result_ready`, and its first element is accepted.
- R11: Gaps of invalid cycles between elements do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | DW | Operand value |
| data_valid | input | 1 | Operand on `data_in` is valid this cycle |
| data_last | input | 1 | With `data_valid`, marks the final operand of the stream |
| result | output | DW | Accumulated total, meaningful while `result_ready` is high |
| result_ready | output | 1 | One-cycle pulse: the total is on `result` |

## Verification
Two events can fall in the same cycle: a new input arriving and a partial sum leaving the adder. When they do, the two are added at once while the register holds a third value. Streams of unbroken valid elements longer than the pipeline depth, and streams with uneven gaps, create many such collisions. The 4-element case with a 2-stage adder creates one at a known cycle. Each run is judged by the exact total seen at the one `result_ready` pulse, and by the cycle of that pulse in the short cases. A dropped or doubled operand shows up as a wrong total, and a register overwritten during a collision also shows up as a wrong total.

// File: rtl/dbacc_pkg.sv
package dbacc_pkg;

    typedef enum logic [2:0] {
        RT_IDLE,
        RT_IN_FB,
        RT_IN_REG,
        RT_FB_REG,
        RT_LOAD_IN,
        RT_LOAD_FB
    } route_e;

    function automatic route_e pick_route(input logic in_v, input logic sum_v, input logic reg_v);
        route_e rt;
        if (in_v && sum_v)      rt = RT_IN_FB;
        else if (in_v && reg_v) rt = RT_IN_REG;
        else if (sum_v && reg_v) rt = RT_FB_REG;
        else if (in_v)          rt = RT_LOAD_IN;
        else if (sum_v)         rt = RT_LOAD_FB;
        else                    rt = RT_IDLE;
        return rt;
    endfunction

    function automatic logic route_pushes(input route_e rt);
        return (rt == RT_IN_FB) || (rt == RT_IN_REG) || (rt == RT_FB_REG);
    endfunction

endpackage

// File: rtl/dbacc_route.sv
module dbacc_route
    import dbacc_pkg::*;
#(
    parameter int DW = 32
) (
    input  route_e          route,
    input  logic [DW-1:0]   data_in,
    input  logic [DW-1:0]   sum,
    input  logic [DW-1:0]   hold_d,
    output logic [DW-1:0]   op_a,
    output logic [DW-1:0]   op_b,
    output logic            push
);
    always_comb begin
        op_a = data_in;
        op_b = sum;
        unique case (route)
            RT_IN_FB:  begin op_a = data_in; op_b = sum;    end
            RT_IN_REG: begin op_a = data_in; op_b = hold_d; end
            RT_FB_REG: begin op_a = hold_d;  op_b = sum;    end
            default:   begin op_a = data_in; op_b = sum;    end
        endcase
    end

    assign push = route_pushes(route);
endmodule

// File: rtl/dbacc_adder_pipe.sv
module dbacc_adder_pipe #(
    parameter int DW  = 32,
    parameter int LAT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    output logic [DW-1:0]   sum,
    output logic            sum_valid,
    output logic            empty
);
    localparam int LAST = LAT - 1;

    logic [DW-1:0] st_d [LAT];
    logic [LAT-1:0] st_v;

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_v[0] <= 1'b0;
                    st_d[0] <= '0;
                end else begin
                    st_v[0] <= push;
                    st_d[0] <= op_a + op_b;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_v[g] <= 1'b0;
                    st_d[g] <= '0;
                end else begin
                    st_v[g] <= st_v[g-1];
                    st_d[g] <= st_d[g-1];
                end
            end
        end
    end

    assign sum       = st_d[LAST];
    assign sum_valid = st_v[LAST];
    assign empty     = ~|st_v;
endmodule

// File: rtl/dbacc_hold.sv
module dbacc_hold
    import dbacc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  route_e          route,
    input  logic            drain,
    input  logic [DW-1:0]   data_in,
    input  logic [DW-1:0]   sum,
    output logic [DW-1:0]   hold_d,
    output logic            hold_v
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (drain) begin
            hold_v <= 1'b0;
        end else begin
            unique case (route)
                RT_LOAD_IN: begin hold_v <= 1'b1; hold_d <= data_in; end
                RT_LOAD_FB: begin hold_v <= 1'b1; hold_d <= sum;     end
                RT_IN_REG,
                RT_FB_REG:  hold_v <= 1'b0;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/dbacc_done.sv
module dbacc_done (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_last,
    input  logic pipe_empty,
    input  logic hold_v,
    output logic last_seen,
    output logic ready
);
    assign ready = last_seen && pipe_empty && hold_v;

    always_ff @(posedge clk) begin
        if (rst)
            last_seen <= 1'b0;
        else if (ready)
            last_seen <= 1'b0;
        else if (take && take_last)
            last_seen <= 1'b1;
    end
endmodule

// File: rtl/dbacc_top.sv
module dbacc_top
    import dbacc_pkg::*;
#(
    parameter int DW  = 32,
    parameter int LAT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   data_in,
    input  logic            data_valid,
    input  logic            data_last,
    output logic [DW-1:0]   result,
    output logic            result_ready
);
    logic            take;
    logic            last_seen;
    logic            pipe_empty;
    logic            sum_valid;
    logic [DW-1:0]   sum;
    logic [DW-1:0]   hold_d;
    logic            hold_v;
    logic [DW-1:0]   op_a;
    logic [DW-1:0]   op_b;
    logic            push;
    route_e          route;

    assign take  = data_valid && !last_seen;
    assign route = pick_route(take, sum_valid, hold_v);

    dbacc_route #(.DW(DW)) u_route (
        .route   (route),
        .data_in (data_in),
        .sum     (sum),
        .hold_d  (hold_d),
        .op_a    (op_a),
        .op_b    (op_b),
        .push    (push)
    );

    dbacc_adder_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .op_a      (op_a),
        .op_b      (op_b),
        .sum       (sum),
        .sum_valid (sum_valid),
        .empty     (pipe_empty)
    );

    dbacc_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .route   (route),
        .drain   (result_ready),
        .data_in (data_in),
        .sum     (sum),
        .hold_d  (hold_d),
        .hold_v  (hold_v)
    );

    dbacc_done u_done (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .take_last  (data_last),
        .pipe_empty (pipe_empty),
        .hold_v     (hold_v),
        .last_seen  (last_seen),
        .ready      (result_ready)
    );

    assign result = hold_d;
endmodule

// File: rtl/dbacc_checks.sv
module dbacc_checks #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          data_valid,
    input logic [DW-1:0] data_in,
    input logic          result_ready,
    input logic          last_seen,
    input logic          pipe_empty,
    input logic          sum_valid,
    input logic          hold_v,
    input logic [DW-1:0] hold_d
);
    logic take;
    assign take = data_valid && !last_seen;

    AST_LONE_TO_REG: assert property (@(posedge clk) disable iff (rst)
        (take && !sum_valid && !hold_v) |=> (hold_v && hold_d == $past(data_in))) // R2
        else $error("lone input not stored");

    AST_IN_REG_PAIR: assert property (@(posedge clk) disable iff (rst)
        (take && !sum_valid && hold_v) |=> !hold_v) // R3
        else $error("input/register pair not issued");

    AST_FB_REG_PAIR: assert property (@(posedge clk) disable iff (rst)
        (!take && sum_valid && hold_v) |=> !hold_v) // R4
        else $error("sum/register pair not issued");

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (take && sum_valid) |=> ($stable(hold_v) && $stable(hold_d))) // R5
        else $error("register disturbed on collision");

    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        result_ready |-> (pipe_empty && hold_v && last_seen)) // R6
        else $error("ready without completion");

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        result_ready |=> !result_ready) // R7
        else $error("ready longer than one cycle");

    AST_IGNORE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (last_seen && !sum_valid && !result_ready) |=> $stable(hold_v)) // R9
        else $error("input taken after last");
endmodule

bind dbacc_top dbacc_checks #(.DW(DW)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .data_valid   (data_valid),
    .data_in      (data_in),
    .result_ready (result_ready),
    .last_seen    (last_seen),
    .pipe_empty   (pipe_empty),
    .sum_valid    (sum_valid),
    .hold_v       (hold_v),
    .hold_d       (hold_d)
);

// File: tb/dbacc_top_tb.sv
module dbacc_top_tb;
    localparam int DW  = 16;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          data_valid = 1'b0;
    logic          data_last = 1'b0;
    logic [DW-1:0] result;
    logic          result_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit prev_ready = 1'b0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbacc_top #(.DW(DW), .LAT(LAT)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .data_in      (data_in),
        .data_valid   (data_valid),
        .data_last    (data_last),
        .result       (result),
        .result_ready (result_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: compares each pulse against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (result_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", int'(result), 0);
                end else begin
                    automatic logic [DW-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(result == e, t, int'(result), int'(e));
                end
                check(!prev_ready, "R7 pulse width", 1, 0);
            end
            prev_ready = result_ready;
        end
    end

    // drive one stream; returns cycles from first element to the ready pulse
    task automatic send(input int n, input int base, input int step, input int gap,
                        input bit junk, input string tag, output int lat);
        logic [DW-1:0] acc = '0;
        int c0 = 0;
        for (int i = 0; i < n; i++) begin
            automatic logic [DW-1:0] v = DW'(base + i * step);
            acc = acc + v;
        end
        exp_q.push_back(acc);
        tag_q.push_back(tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) c0 = cyc;
            data_valid = 1'b1;
            data_in    = DW'(base + i * step);
            data_last  = (i == n - 1);
            if (gap > 0 && i != n - 1 && (i % 3) == 1) begin
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk);
                    data_valid = 1'b0;
                    data_last  = 1'b0;
                    data_in    = 16'hDEAD;
                end
            end
        end
        forever begin
            @(negedge clk);
            if (result_ready) begin
                data_valid = 1'b0;
                data_last  = 1'b0;
                lat = cyc - c0;
                break;
            end
            data_valid = junk;
            data_last  = junk;
            data_in    = 16'h1234;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        check(result_ready == 1'b0, "R1 ready in reset", int'(result_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check(result_ready == 1'b0, "R1 ready after reset", int'(result_ready), 0);

        send(1, 16'h0042, 0, 0, 0, "R2 single element", lat);
        check(lat == 1, "R2 single latency", lat, 1);

        send(2, 5, 4, 0, 0, "R3 two elements", lat);
        check(lat == 4, "R8 two-element latency", lat, 4);

        send(4, 1, 1, 0, 0, "R5 four-element collision", lat);
        check(lat == 8, "R8 four-element latency", lat, 8);

        send(3, 10, 7, 0, 0, "R4 three elements", lat);
        send(17, 3, 11, 0, 0, "R6 long stream", lat);
        send(40, 1000, 37, 0, 0, "R5 streaming collisions", lat);
        send(20, 7, 3, 2, 0, "R11 gapped stream", lat);
        send(9, 100, 1, 1, 0, "R11 short gaps", lat);
        send(5, 50, 5, 0, 1, "R9 input after last ignored", lat);
        send(6, 2, 9, 0, 0, "R10 back-to-back start", lat);
        send(1, 16'h7777, 0, 0, 1, "R9 single with junk", lat);
        send(3, 16'hF000, 0, 0, 0, "R7 wrap modulo", lat);
        send(2, 16'hFFFF, 0, 0, 0, "R7 wrap two", lat);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R7 missing results", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule